// File: doc/BRIEF.md
# Cluster Directory Coherence Engine

This block sits at a cluster's network interface. It tracks which remote clusters hold copies of lines that live in this cluster's memory. Each request arriving from the home cluster (cluster 0) or from a remote cluster is looked up in a small directory. The block updates the line's status and its per-cluster holder vector. It then sends the messages the request needs on a valid/ready port: invalidates to other holders, or a recall of a dirty line from its owner.

A request completes with a one-cycle done pulse once every sent message has been answered on the response port. The engine handles one request at a time, so a later request to the same line waits until the earlier one has finished. When a remote cluster misses and every directory slot is in use, the request completes at once with a retry flag. The requester backs off and issues it again later.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset the engine is idle: req_ready is 1, msg_valid is 0 and done_valid is 0.
- R2: One request at a time: req_ready is 0 from the cycle after a request is accepted until the cycle after its done pulse, and no message or done is issued while req_ready is 1.
- R3: A remote read of an untracked line, with a free slot, creates an entry in status Exclusive with the requester as sole holder. No message is sent and done_retry is 0.
- R4: A remote read of a line in status Shared adds the requester to the holders, keeps status Shared and sends no message.
- R5: A write to a Shared line sends one invalidate (msg_kind 0) to every holder other than the requester. Targets go out in ascending cluster order, one per accepted message, each held stable while msg_ready is 0. After a remote write the line is Exclusive to the writer.
- R6: A request to a line held Exclusive by another cluster sends exactly one fetch (msg_kind 1) to the owner first. Afterwards a remote read leaves the line Shared by owner and reader, a remote write leaves it Exclusive to the writer, and a home read leaves it Shared by the owner alone.
- R7: The done pulse appears only after every sent message has been answered on the response port. A response from a cluster not currently owed one is ignored.
- R8: A home-cluster write invalidates or recalls every remote copy and frees the line's entry. A home request to an untracked line sends no message and allocates nothing.
- R9: A remote miss while all slots are in use completes with done_retry 1, sends no message and leaves the directory unchanged.
- R10: A cluster that is sole Exclusive owner re-reading or re-writing its line sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken |
| req_src | input | CW | Requesting cluster, 0 = home |
| req_addr | input | AW | Line address |
| req_write | input | 1 | 1 = write, 0 = read |
| msg_valid | output | 1 | Outbound message offered |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 1 | 0 = invalidate, 1 = fetch dirty line |
| msg_dst | output | CW | Target cluster |
| msg_addr | output | AW | Line address |
| rsp_valid | input | 1 | Acknowledge or returned data |
| rsp_src | input | CW | Responding cluster |
| done_valid | output | 1 | Request complete pulse |
| done_src | output | CW | Requester of the completed request |
| done_addr | output | AW | Line of the completed request |
| done_write | output | 1 | Completed request was a write |
| done_retry | output | 1 | Directory full, requester must retry |

## Verification
Directed sequences walk one line through every status change. The steps are a miss, a read recall from an owner, a second reader joining, a write fanning out to two holders, an owner's repeat write, a home read recall and a home write that frees the entry. Each step shows whether the holder vector and status left by the step before are correct. A fill of every slot followed by one more remote miss separates the retry path from allocation. Several hundred random requests over six lines, with random msg_ready back-pressure, randomly delayed responses and stray responses from the home cluster, stress message order and stability. They also check that completion waits for the real acknowledgements and not for the stray ones.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the directory coherence engine.
// Assumes one-bit message kinds and one-bit line status.
package coh_dir_pkg;
    typedef enum logic {
        MSG_INV   = 1'b0,
        MSG_FETCH = 1'b1
    } msg_kind_e;

    typedef enum logic {
        LN_SHARED = 1'b0,
        LN_EXCL   = 1'b1
    } line_st_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_SEND,
        S_WAIT,
        S_COMMIT
    } eng_st_e;
endpackage

// File: rtl/coh_dir_store.sv
// Directory slot array: address, status and holder vector per slot.
// Fully associative lookup on one address and one write port.
// The lowest matching slot and the lowest free slot win.
// Assumes the writer never creates two valid slots with the same address.
module coh_dir_store #(
    parameter int AW   = 8,
    parameter int NC   = 4,
    parameter int NENT = 4,
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic          lk_excl,
    output logic [NC-1:0] lk_sharers,
    output logic [IW-1:0] free_idx,
    output logic          full,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_valid,
    input  logic          wr_excl,
    input  logic [AW-1:0] wr_addr,
    input  logic [NC-1:0] wr_sharers
);
    logic          e_valid [NENT];
    logic          e_excl  [NENT];
    logic [AW-1:0] e_addr  [NENT];
    logic [NC-1:0] e_sh    [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_slot
        // Update one slot when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[g] <= 1'b0;
                e_excl[g]  <= 1'b0;
                e_addr[g]  <= '0;
                e_sh[g]    <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                e_valid[g] <= wr_valid;
                e_excl[g]  <= wr_excl;
                e_addr[g]  <= wr_addr;
                e_sh[g]    <= wr_valid ? wr_sharers : '0;
            end
        end
    end

    // Find the matching slot and the lowest free slot.
    always_comb begin
        lk_hit   = 1'b0;
        lk_idx   = '0;
        free_idx = '0;
        full     = 1'b1;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (e_valid[i] && (e_addr[i] == lk_addr)) begin
                lk_hit = 1'b1;
                lk_idx = IW'(i);
            end
            if (!e_valid[i]) begin
                full     = 1'b0;
                free_idx = IW'(i);
            end
        end
    end

    // Read out the fields of the matched slot.
    always_comb begin
        lk_excl    = e_excl[lk_idx];
        lk_sharers = e_sh[lk_idx];
    end
endmodule

// File: rtl/coh_dir_pick.sv
// Lowest-set-bit picker used to order outbound messages by cluster.
// Assumes NC is at least 2.
module coh_dir_pick #(
    parameter int NC  = 4,
    localparam int CW = $clog2(NC)
) (
    input  logic [NC-1:0] vec,
    output logic [CW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set bit is kept.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = CW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_dir_ctrl.sv
// Directory coherence engine for one cluster's memory.
// Takes one request at a time. It looks the line up, works out the message
// targets and the new entry, sends the messages in ascending cluster order,
// waits for every response, then writes the entry and pulses done.
// Assumes cluster 0 is the home cluster and never appears in a holder
// vector. It also assumes each message target answers exactly once.
module coh_dir_ctrl #(
    parameter int NCLUST = 4,
    parameter int AW     = 8,
    parameter int NENT   = 4,
    localparam int CW    = $clog2(NCLUST),
    localparam int IW    = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int OW    = $clog2(NCLUST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_src,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic          msg_kind,
    output logic [CW-1:0] msg_dst,
    output logic [AW-1:0] msg_addr,
    input  logic          rsp_valid,
    input  logic [CW-1:0] rsp_src,
    output logic          done_valid,
    output logic [CW-1:0] done_src,
    output logic [AW-1:0] done_addr,
    output logic          done_write,
    output logic          done_retry
);
    import coh_dir_pkg::*;

    eng_st_e           state;
    logic [CW-1:0]     r_src;
    logic [AW-1:0]     r_addr;
    logic              r_write;
    logic              r_kind;
    logic              r_retry;
    logic [NCLUST-1:0] pend;
    logic [NCLUST-1:0] awaiting;
    logic [OW-1:0]     outst;
    logic              n_wr;
    logic [IW-1:0]     n_idx;
    logic              n_valid;
    logic              n_excl;
    logic [NCLUST-1:0] n_sh;

    logic              lk_hit;
    logic [IW-1:0]     lk_idx;
    logic              lk_excl;
    logic [NCLUST-1:0] lk_sharers;
    logic [IW-1:0]     free_idx;
    logic              full;

    logic [CW-1:0]     pick_idx;
    logic              pick_any;
    logic [NCLUST-1:0] pick_bit;
    logic [NCLUST-1:0] src_bit;
    logic [NCLUST-1:0] rsp_bit;
    logic              is_home;
    logic              fire;
    logic              ack;

    logic [NCLUST-1:0] ev_pend;
    logic              ev_kind;
    logic              ev_wr;
    logic              ev_valid;
    logic              ev_excl;
    logic [NCLUST-1:0] ev_sh;
    logic              ev_retry;

    coh_dir_store #(.AW(AW), .NC(NCLUST), .NENT(NENT)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (r_addr),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_excl    (lk_excl),
        .lk_sharers (lk_sharers),
        .free_idx   (free_idx),
        .full       (full),
        .wr_en      (state == S_COMMIT && n_wr),
        .wr_idx     (n_idx),
        .wr_valid   (n_valid),
        .wr_excl    (n_excl),
        .wr_addr    (r_addr),
        .wr_sharers (n_sh)
    );

    coh_dir_pick #(.NC(NCLUST)) u_pick (
        .vec (pend),
        .idx (pick_idx),
        .any (pick_any)
    );

    // Decode cluster ids into one-hot vectors and handshake events.
    always_comb begin
        pick_bit = NCLUST'(1) << pick_idx;
        src_bit  = NCLUST'(1) << r_src;
        rsp_bit  = NCLUST'(1) << rsp_src;
        is_home  = (r_src == '0);
        fire     = (state == S_SEND) && pick_any && msg_ready;
        ack      = ((state == S_SEND) || (state == S_WAIT)) && rsp_valid
                   && ((awaiting & rsp_bit) != '0);
    end

    // Work out message targets and the next directory entry for the request.
    always_comb begin
        ev_pend  = '0;
        ev_kind  = MSG_INV;
        ev_wr    = 1'b0;
        ev_valid = 1'b1;
        ev_excl  = LN_SHARED;
        ev_sh    = '0;
        ev_retry = 1'b0;
        if (!lk_hit) begin
            if (!is_home) begin
                if (full) begin
                    ev_retry = 1'b1;
                end else begin
                    ev_wr   = 1'b1;
                    ev_excl = LN_EXCL;
                    ev_sh   = src_bit;
                end
            end
        end else if (lk_excl) begin
            if (lk_sharers != src_bit) begin
                ev_pend = lk_sharers;
                ev_kind = MSG_FETCH;
                ev_wr   = 1'b1;
                if (is_home) begin
                    ev_valid = !r_write;
                    ev_sh    = r_write ? '0 : lk_sharers;
                end else if (r_write) begin
                    ev_excl = LN_EXCL;
                    ev_sh   = src_bit;
                end else begin
                    ev_sh = lk_sharers | src_bit;
                end
            end
        end else if (!r_write) begin
            if (!is_home) begin
                ev_wr = 1'b1;
                ev_sh = lk_sharers | src_bit;
            end
        end else begin
            ev_pend = lk_sharers & ~src_bit;
            ev_kind = MSG_INV;
            ev_wr   = 1'b1;
            if (is_home) begin
                ev_valid = 1'b0;
            end else begin
                ev_excl = LN_EXCL;
                ev_sh   = src_bit;
            end
        end
    end

    // Request sequencing: accept, evaluate, send, wait, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            r_src   <= '0;
            r_addr  <= '0;
            r_write <= 1'b0;
            r_kind  <= MSG_INV;
            r_retry <= 1'b0;
            pend    <= '0;
            n_wr    <= 1'b0;
            n_idx   <= '0;
            n_valid <= 1'b0;
            n_excl  <= 1'b0;
            n_sh    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        r_src   <= req_src;
                        r_addr  <= req_addr;
                        r_write <= req_write;
                        state   <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    pend    <= ev_pend;
                    r_kind  <= ev_kind;
                    r_retry <= ev_retry;
                    n_wr    <= ev_wr;
                    n_idx   <= lk_hit ? lk_idx : free_idx;
                    n_valid <= ev_valid;
                    n_excl  <= ev_excl;
                    n_sh    <= ev_sh;
                    state   <= (ev_pend != '0) ? S_SEND : S_COMMIT;
                end
                S_SEND: begin
                    if (fire) begin
                        pend <= pend & ~pick_bit;
                        if (pend == pick_bit) begin
                            state <= S_WAIT;
                        end
                    end
                end
                S_WAIT: begin
                    if (outst == '0) begin
                        state <= S_COMMIT;
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // Track which targets still owe a response and how many.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awaiting <= '0;
            outst    <= '0;
        end else begin
            awaiting <= (awaiting | (fire ? pick_bit : '0)) & ~(ack ? rsp_bit : '0);
            outst    <= outst + OW'(fire) - OW'(ack);
        end
    end

    // Drive the port outputs from the sequencing state.
    always_comb begin
        req_ready  = (state == S_IDLE);
        msg_valid  = (state == S_SEND) && pick_any;
        msg_kind   = r_kind;
        msg_dst    = pick_idx;
        msg_addr   = r_addr;
        done_valid = (state == S_COMMIT);
        done_src   = r_src;
        done_addr  = r_addr;
        done_write = r_write;
        done_retry = r_retry;
    end
endmodule

// File: rtl/coh_dir_ctrl_chk.sv
// Protocol checker for the directory coherence engine, bound to the top.
// Keeps its own record of clusters that owe a response.
module coh_dir_ctrl_chk #(
    parameter int NCLUST = 4,
    parameter int AW     = 8,
    localparam int CW    = $clog2(NCLUST)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          msg_valid,
    input logic          msg_ready,
    input logic          msg_kind,
    input logic [CW-1:0] msg_dst,
    input logic [AW-1:0] msg_addr,
    input logic          rsp_valid,
    input logic [CW-1:0] rsp_src,
    input logic          done_valid,
    input logic          done_retry
);
    logic [NCLUST-1:0] owed;
    logic              sent_flag;

    // Record messages sent and responses returned since the last accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed      <= '0;
            sent_flag <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                sent_flag <= 1'b0;
            end else if (msg_valid && msg_ready) begin
                sent_flag <= 1'b1;
            end
            owed <= (owed | ((msg_valid && msg_ready) ? (NCLUST'(1) << msg_dst) : '0))
                    & ~((rsp_valid && owed[rsp_src]) ? (NCLUST'(1) << rsp_src) : '0);
        end
    end

    // R2
    busy_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !req_ready);

    // R2
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !req_ready);

    // R5
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dst)
                                       && $stable(msg_kind) && $stable(msg_addr)));

    // R5
    no_home_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_dst != '0));

    // R7
    acks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (owed == '0));

    // R9
    retry_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_retry) |-> !sent_flag);
endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.NCLUST(NCLUST), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_kind   (msg_kind),
    .msg_dst    (msg_dst),
    .msg_addr   (msg_addr),
    .rsp_valid  (rsp_valid),
    .rsp_src    (rsp_src),
    .done_valid (done_valid),
    .done_retry (done_retry)
);

// File: tb/coh_dir_ctrl_bench.sv
// Self-checking bench: directed line walk, directory fill, then random traffic.
module coh_dir_ctrl_bench;
    localparam int NCLUST = 4;
    localparam int AW     = 8;
    localparam int NENT   = 4;
    localparam int CW     = 2;
    localparam int NA     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic          msg_kind;
    logic [CW-1:0] msg_dst;
    logic [AW-1:0] msg_addr;
    logic          rsp_valid = 1'b0;
    logic [CW-1:0] rsp_src = '0;
    logic          done_valid;
    logic [CW-1:0] done_src;
    logic [AW-1:0] done_addr;
    logic          done_write;
    logic          done_retry;

    int checks = 0;
    int fails  = 0;

    // Reference directory model, indexed by line number.
    bit       mv  [NA];
    bit       mex [NA];
    bit [3:0] msh [NA];

    always #4 clk = ~clk;

    coh_dir_ctrl #(.NCLUST(NCLUST), .AW(AW), .NENT(NENT)) u_coh_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_addr(req_addr), .req_write(req_write),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dst(msg_dst), .msg_addr(msg_addr),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src),
        .done_valid(done_valid), .done_src(done_src), .done_addr(done_addr),
        .done_write(done_write), .done_retry(done_retry)
    );

    function automatic logic [AW-1:0] line_addr(input int ai);
        return AW'(ai * 3 + 5);
    endfunction

    function automatic int used_slots();
        int n = 0;
        for (int i = 0; i < NA; i++) n += mv[i];
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request, serve the network randomly and compare with the model.
    task automatic run_req(input int src, input int ai, input bit w);
        bit [3:0] sb = 4'(1 << src);
        bit       home = (src == 0);
        bit [3:0] exp_mask = '0;
        bit       exp_kind = 1'b0;
        bit       exp_retry = 1'b0;
        string    tag;
        bit [3:0] got_mask = '0;
        int       last_dst = -1;
        bit       busy = 1'b0;
        bit       finished = 1'b0;
        int       owed_q[$];
        int       fired = 0;

        if (!mv[ai]) begin
            if (!home && used_slots() == NENT) begin
                exp_retry = 1'b1; tag = "R9";
            end else if (!home) begin
                mv[ai] = 1; mex[ai] = 1; msh[ai] = sb; tag = "R3";
            end else begin
                tag = "R8";
            end
        end else if (mex[ai]) begin
            if (msh[ai] == sb) begin
                tag = "R10";
            end else begin
                exp_mask = msh[ai]; exp_kind = 1'b1; tag = "R6";
                if (home && w) begin mv[ai] = 0; mex[ai] = 0; msh[ai] = '0; end
                else if (home) begin mex[ai] = 0; end
                else if (w) begin msh[ai] = sb; end
                else begin mex[ai] = 0; msh[ai] = msh[ai] | sb; end
            end
        end else if (!w) begin
            tag = home ? "R8" : "R4";
            if (!home) msh[ai] = msh[ai] | sb;
        end else begin
            exp_mask = msh[ai] & ~sb; exp_kind = 1'b0;
            tag = home ? "R8" : "R5";
            if (home) begin mv[ai] = 0; msh[ai] = '0; end
            else begin mex[ai] = 1; msh[ai] = sb; end
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "idle before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_src   = CW'(src);
        req_addr  = line_addr(ai);
        req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (req_ready) busy = 1'b1;
            if (done_valid) begin
                finished = 1'b1;
                break;
            end
            rsp_valid = 1'b0;
            if (owed_q.size() > 0 && ($urandom % 2) == 0) begin
                rsp_valid = 1'b1;
                rsp_src   = CW'(owed_q.pop_front());
            end else if (($urandom % 4) == 0) begin
                rsp_valid = 1'b1;
                rsp_src   = '0;
            end
            msg_ready = (($urandom % 3) != 0);
            if (msg_valid && msg_ready) begin
                chk(msg_kind == exp_kind, tag, "message kind", int'(msg_kind), int'(exp_kind));
                chk(msg_addr == line_addr(ai), tag, "message address",
                    int'(msg_addr), int'(line_addr(ai)));
                chk(int'(msg_dst) > last_dst, tag, "ascending target order",
                    int'(msg_dst), last_dst + 1);
                last_dst = int'(msg_dst);
                got_mask[msg_dst] = 1'b1;
                owed_q.push_back(int'(msg_dst));
                fired++;
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        msg_ready = 1'b0;
        chk(finished, tag, "request completed", int'(finished), 1);
        chk(!busy, "R2", "req_ready low while busy", int'(busy), 0);
        chk(got_mask == exp_mask, tag, "message targets", int'(got_mask), int'(exp_mask));
        chk(owed_q.size() == 0, "R7", "done before responses", owed_q.size(), 0);
        chk(done_retry == exp_retry, tag, "retry flag", int'(done_retry), int'(exp_retry));
        chk(done_addr == line_addr(ai) && done_src == CW'(src) && done_write == w,
            tag, "done fields", int'(done_addr), int'(line_addr(ai)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NA; i++) begin mv[i] = 0; mex[i] = 0; msh[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", int'(msg_valid), 0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", int'(done_valid), 0);

        run_req(1, 0, 0);   // R3 miss allocates Exclusive
        run_req(2, 0, 0);   // R6 read recall from owner 1
        run_req(3, 0, 0);   // R4 third reader joins
        run_req(2, 0, 1);   // R5 invalidates to 1 and 3
        run_req(2, 0, 1);   // R10 owner writes again
        run_req(0, 0, 0);   // R6 home read recall
        run_req(0, 0, 1);   // R8 home write frees entry
        run_req(0, 1, 0);   // R8 home miss, no allocation
        run_req(1, 1, 0);
        run_req(1, 2, 0);
        run_req(1, 3, 0);
        run_req(1, 4, 0);
        run_req(2, 5, 0);   // R9 directory full
        run_req(0, 1, 1);   // R8 frees a slot
        run_req(2, 5, 0);   // R3 retry now succeeds

        for (int n = 0; n < 400; n++) begin
            run_req(int'($urandom % NCLUST), int'($urandom % NA), (($urandom % 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule